// File: doc/BRIEF.md
# Per-Port Input Change Interrupt

This block raises one active-low interrupt request for a general-purpose I/O expander that has several 8-bit ports (two by default). For each port it keeps a snapshot of the pin levels taken at the last read of that port's input register. While any pin configured as an input differs from its snapshot, the request is held active. The request removes itself when the pins return to the snapshot value. It is also removed when the port whose pins changed is read, because the read reloads that port's snapshot from the current pins.

The block takes pin levels that have already been synchronised, the per-pin direction masks, and one read strobe per port. It produces the interrupt level and the matching pull-down enable for an open-drain pad. Register storage and bus decoding are outside the block.

The request is registered. A pin change presented before a clock edge shows up on the outputs right after that edge. A read strobe takes effect at the same edge.

Top module: `port_change_irq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `irq_n_o` is 1. During reset each snapshot follows the pins on every edge, so pins that do not move across reset release raise no request.
- R2: Pin i of port p is bit p*8+i of `pin_i`, `dir_i` and the snapshot, and `dir_i` bit = 1 marks an input. When an input pin differs from its snapshot, `irq_n_o` is 0 in the cycle after the edge that sampled the pin.
- R3: When every input pin returns to its snapshot value, `irq_n_o` goes back to 1 one edge later, with no read needed.
- R4: A read strobe `rd_i[p]` reloads port p's snapshot from the current pins at that edge. From the next cycle that port raises no request until its pins move again.
- R5: A read strobe on one port neither clears nor reloads another port's request or snapshot.
- R6: A pin whose `dir_i` bit is 0 never causes a request. Turning a differing pin into an output removes its request one edge later. Turning it back into an input restores the request, because its snapshot was not reloaded.
- R7: The interrupt is active low, and the open-drain pull-down enable `irq_pd_en_o` is 1 exactly when `irq_n_o` is 0.
- R8: A pin change that meets a read strobe of its own port at the same edge is absorbed into the new snapshot and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PORTS*PORT_W | Synchronised pin levels, port p in bits p*PORT_W and up |
| dir_i | input | NUM_PORTS*PORT_W | Direction mask, 1 = input, 0 = output |
| rd_i | input | NUM_PORTS | Per-port input-register read strobe |
| irq_n_o | output | 1 | Interrupt level, active low |
| irq_pd_en_o | output | 1 | Pad pull-down enable, 1 drives the line low |

## Verification
Two functions can meet at one clock edge: the read that clears a port, and a fresh mismatch on a pin. The bench provokes this twice. First it flips a port-0 pin together with a port-0 read: the read must win, and the change must land silently in the snapshot. Then it pulses a port-0 read at the same edge as a port-1 pin change: the request must still appear, because that read may reload only port 0. Each case is judged on both outputs one edge later, and again a cycle after that to confirm which snapshots were reloaded.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

    localparam int unsigned PORTS_DEFAULT = 2;
    localparam int unsigned WIDTH_DEFAULT = 8;
    localparam int unsigned WIDTH_MAX     = 32;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic hit;      // an input pin disagrees with its snapshot
        logic cleared;  // a read reloads the snapshot this edge
    } port_term_t;

    function automatic logic live_diff(input logic [WIDTH_MAX-1:0] now_v,
                                       input logic [WIDTH_MAX-1:0] snap_v,
                                       input logic [WIDTH_MAX-1:0] in_mask);
        return |((now_v ^ snap_v) & in_mask);
    endfunction

    function automatic logic term_raises(input port_term_t t);
        return t.hit && !t.cleared;
    endfunction

endpackage

// File: rtl/port_snapshot.sv
module port_snapshot
    import chg_irq_pkg::*;
#(
    parameter int unsigned PORT_W = WIDTH_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pin_i,
    input  logic [PORT_W-1:0] dir_i,
    input  logic              rd_i,
    output port_term_t        term_o
);

    logic [PORT_W-1:0]    snap_q;
    logic [WIDTH_MAX-1:0] pin_ext, snap_ext, dir_ext;

    always_comb begin
        pin_ext  = '0;
        snap_ext = '0;
        dir_ext  = '0;
        pin_ext[PORT_W-1:0]  = pin_i;
        snap_ext[PORT_W-1:0] = snap_q;
        dir_ext[PORT_W-1:0]  = dir_i;
    end

    // During reset the snapshot follows the pins, so the first
    // sample after release already matches.
    always_ff @(posedge clk) begin
        if (rst || rd_i) begin
            snap_q <= pin_i;
        end
    end

    always_comb begin
        term_o.hit     = live_diff(pin_ext, snap_ext, dir_ext);
        term_o.cleared = rd_i;
    end

endmodule

// File: rtl/irq_merge.sv
module irq_merge
    import chg_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = PORTS_DEFAULT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  port_term_t [NUM_PORTS-1:0] terms_i,
    output logic                       irq_n_o,
    output logic                       irq_pd_en_o
);

    irq_state_e state_q, state_d;
    logic [NUM_PORTS-1:0] raise;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_raise
        assign raise[p] = term_raises(terms_i[p]);
    end

    always_comb begin
        state_d = (|raise) ? IRQ_ACTIVE : IRQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_pd_en_o = (state_q == IRQ_ACTIVE);
    assign irq_n_o     = (state_q != IRQ_ACTIVE);

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
    import chg_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = PORTS_DEFAULT,
    parameter int unsigned PORT_W    = WIDTH_DEFAULT
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_i,
    input  logic [NUM_PORTS*PORT_W-1:0]   dir_i,
    input  logic [NUM_PORTS-1:0]          rd_i,
    output logic                          irq_n_o,
    output logic                          irq_pd_en_o
);

    localparam int unsigned TOTAL_W = NUM_PORTS * PORT_W;

    port_term_t [NUM_PORTS-1:0] terms;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_snapshot #(
            .PORT_W (PORT_W)
        ) u_snap (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pin_i[p*PORT_W +: PORT_W]),
            .dir_i  (dir_i[p*PORT_W +: PORT_W]),
            .rd_i   (rd_i[p]),
            .term_o (terms[p])
        );
    end

    irq_merge #(
        .NUM_PORTS (NUM_PORTS)
    ) u_merge (
        .clk         (clk),
        .rst         (rst),
        .terms_i     (terms),
        .irq_n_o     (irq_n_o),
        .irq_pd_en_o (irq_pd_en_o)
    );

    initial begin
        if (PORT_W > WIDTH_MAX || PORT_W == 0 || NUM_PORTS == 0 || TOTAL_W == 0) begin
            $error("port_change_irq: unsupported geometry");
        end
    end

endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk #(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned PORT_W    = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_PORTS*PORT_W-1:0] pin_i,
    input logic [NUM_PORTS*PORT_W-1:0] dir_i,
    input logic [NUM_PORTS-1:0]        rd_i,
    input logic                        irq_n_o,
    input logic                        irq_pd_en_o
);

    localparam int unsigned TOTAL_W = NUM_PORTS * PORT_W;

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> irq_n_o) else $error("request after reset");  // R1

    AST_OUTPUTS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dir_i) == '0) |-> irq_n_o) else $error("output pin raised request");  // R6

    AST_FULL_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_i) == '1) |-> irq_n_o) else $error("full read left request");  // R4

    AST_PAD_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (rst)
        $onehot({irq_n_o, irq_pd_en_o})) else $error("pad enable disagrees");  // R7

    AST_QUIET_INPUTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(pin_i) && $stable(dir_i) && $past(rd_i) == '0 && rd_i == '0)
        |=> $stable(irq_n_o)) else $error("request moved with quiet inputs");  // R3

    if (NUM_PORTS > 1) begin : g_iso
        AST_PORT0_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(rd_i[0]) && $past(dir_i[TOTAL_W-1:PORT_W]) == '0)
            |-> irq_n_o) else $error("port 0 read left own request");  // R5
    end

endmodule

bind port_change_irq port_change_irq_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pin_i       (pin_i),
    .dir_i       (dir_i),
    .rd_i        (rd_i),
    .irq_n_o     (irq_n_o),
    .irq_pd_en_o (irq_pd_en_o)
);

// File: tb/port_change_irq_tb.sv
`timescale 1ns/1ps
module port_change_irq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] pin;
    logic [15:0] dir;
    logic [1:0]  rd;
    logic        irq_n;
    logic        irq_pd;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    port_change_irq u_dut (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin),
        .dir_i       (dir),
        .rd_i        (rd),
        .irq_n_o     (irq_n),
        .irq_pd_en_o (irq_pd)
    );

    // inputs change at the falling edge; one rising edge later the
    // registered request reflects them, sampled at the next falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_irq(input bit active, input string req);
        checks++;
        if (irq_n !== !active || irq_pd !== active) begin
            errors++;
            $display("FAIL %s: irq_n=%b pd_en=%b expected irq_n=%b pd_en=%b",
                     req, irq_n, irq_pd, !active, active);
        end
    endtask

    task automatic read_ports(input logic [1:0] which);
        rd = which;
        tick();
        rd = 2'b00;
    endtask

    task automatic t_reset();
        rst = 1'b1; pin = 16'h1234; dir = 16'hFFFF; rd = 2'b00;
        tick(); tick();
        pin = 16'h5A5A;
        tick();
        expect_irq(0, "R1 during reset");
        rst = 1'b0;
        tick();
        expect_irq(0, "R1 first cycle after reset");
        tick();
        expect_irq(0, "R1 snapshot follows pins in reset");
    endtask

    task automatic t_change_and_return();
        pin[3] = ~pin[3];
        tick();
        expect_irq(1, "R2 input pin changed");
        expect_irq(1, "R7 pull-down enable active");
        pin[3] = ~pin[3];
        tick();
        expect_irq(0, "R3 pin returned");
    endtask

    task automatic t_read_clears();
        pin[3] = ~pin[3];
        tick();
        expect_irq(1, "R4 before read");
        read_ports(2'b01);
        expect_irq(0, "R4 read cleared port");
        tick();
        expect_irq(0, "R4 snapshot reloaded");
    endtask

    task automatic t_isolation();
        pin[9] = ~pin[9];
        pin[0] = ~pin[0];
        tick();
        expect_irq(1, "R5 both ports differ");
        read_ports(2'b01);
        expect_irq(1, "R5 port 0 read keeps port 1");
        read_ports(2'b10);
        expect_irq(0, "R5 port 1 read clears rest");
        pin[14] = ~pin[14];
        tick();
        read_ports(2'b01);
        expect_irq(1, "R5 port 0 read did not reload port 1");
        read_ports(2'b10);
        expect_irq(0, "R5 resync");
    endtask

    task automatic t_outputs();
        dir = 16'h00FF;
        tick();
        pin[12] = ~pin[12];
        tick();
        expect_irq(0, "R6 output pin ignored");
        dir = 16'hFFFF;
        tick();
        expect_irq(1, "R6 back to input restores request");
        dir = 16'hEFFF;
        tick();
        expect_irq(0, "R6 turned to output removes request");
        dir = 16'hFFFF;
        read_ports(2'b11);
        expect_irq(0, "R6 resync");
    endtask

    task automatic t_same_edge();
        pin[5] = ~pin[5];
        rd = 2'b01;
        tick();
        rd = 2'b00;
        expect_irq(0, "R8 change absorbed by own read");
        tick();
        expect_irq(0, "R8 snapshot took new level");
        pin[10] = ~pin[10];
        rd = 2'b01;
        tick();
        rd = 2'b00;
        expect_irq(1, "R5 other-port change at read edge");
        read_ports(2'b10);
        expect_irq(0, "R4 final clear");
    endtask

    initial begin
        t_reset();
        t_change_and_return();
        t_read_clears();
        t_isolation();
        t_outputs();
        t_same_edge();
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: run hung, expected completion");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule